// File: doc/BRIEF.md
# Dual Byte FIFO with Threshold and Error Interrupts

This block sits between a register-side host and a byte-serial engine. It holds a transmit queue, which the host fills and the engine drains, and a receive queue, which the engine fills and the host drains. It reports both fill levels and their full and empty flags in one status word. It compares each level against a programmable trigger and latches overrun and underrun errors for each direction. Every interrupt source feeds a write-one-to-clear status register, and a per-bit enable mask gates that register onto a single interrupt line.

A trailing-data timer covers the case where a short burst of received bytes never reaches the receive trigger. The timer counts idle clocks while the receive queue holds data below its trigger. When the count reaches a programmed limit, it raises an interrupt so the host can collect the leftover bytes. The queue depth is a parameter, a power of two up to 64, with 16 and 64 as the intended values.

Top module: `dual_fifo_irq`

## Requirements
- R1: After reset both levels are zero and both empty flags are set. The control word, the interrupt status, the enables and `irq` are zero, and the trailing idle limit is 15.
- R2: Each queue returns bytes in the order they were accepted. The status word holds TX level in bits 6:0, TX full at bit 7, TX empty at bit 8, RX level in bits 22:16, RX full at bit 23 and RX empty at bit 24; all other bits read zero.
- R3: A level never exceeds the depth. The full flag is set exactly when level equals depth, and the empty flag is set exactly when level is zero.
- R4: A host write to a full TX queue drops the byte and sets status bit 3. An engine push to a full RX queue drops the byte and sets status bit 5.
- R5: An engine pop of an empty TX queue sets status bit 2. A host read of an empty RX queue sets status bit 4. In both cases the data output reads zero and the level does not change.
- R6: Status bit 0 (TX almost-empty) is set on each clock edge at which TX is enabled and the TX level is at or below the TX trigger (control bits 22:16).
- R7: Status bit 1 (RX almost-full) is set on each clock edge at which RX is enabled and the RX level is at or above the RX trigger (control bits 10:4).
- R8: Writing the clear register clears each status bit written as 1 and leaves the others. A source that is active on the same edge wins over the clear.
- R9: `irq` is high exactly when some status bit and the same enable bit are both set. An enable of zero masks every source.
- R10: Status bit 6 (trailing) sets on the (limit+1)-th clock edge after the last RX push or pop. This happens only while RX is enabled and non-empty with its level below the RX trigger throughout that interval. Any RX push or pop restarts the count, and the bit fires once per idle interval.
- R11: Control bit 0 enables RX and bit 1 enables TX. A disabled queue is flushed to level zero on the next edge. Its writes and reads are ignored and set no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Write strobe for the control word |
| ctrlWdata | input | 32 | Control word: enables and trigger levels |
| trailWe | input | 1 | Write strobe for the trailing idle limit |
| trailWdata | input | TRAILW | Trailing idle limit in clocks |
| intEnWe | input | 1 | Write strobe for the interrupt enable mask |
| intEnWdata | input | 7 | Interrupt enable mask |
| intClrWe | input | 1 | Write strobe for the status clear |
| intClrWdata | input | 7 | Bits to clear in the interrupt status |
| hostTxWe | input | 1 | Host writes one byte into TX |
| hostTxData | input | 8 | Byte written into TX |
| hostRxRe | input | 1 | Host takes one byte from RX |
| hostRxData | output | 8 | RX head byte, zero when empty |
| engTxRe | input | 1 | Engine takes one byte from TX |
| engTxData | output | 8 | TX head byte, zero when empty |
| engRxWe | input | 1 | Engine pushes one byte into RX |
| engRxData | input | 8 | Byte pushed into RX |
| fifoStatus | output | 32 | Levels and full and empty flags |
| intStatus | output | 7 | Latched interrupt status |
| intEnable | output | 7 | Current enable mask |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a depth of 16 and an 8-bit idle limit, so a few dozen operations reach full and overrun in both directions, and the trigger range of 0 to 16 covers both threshold comparisons at their extremes. With the default limit of 15, the trailing interrupt lands on a known edge that the bench can count. Random traffic with occasional reconfiguration, including disabling a queue that still holds data, then exercises flush, restart of the idle count and clear-versus-set collisions.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
  localparam int INT_W  = 7;

  // control word field positions
  localparam int CTL_RXEN = 0;
  localparam int CTL_TXEN = 1;
  localparam int CTL_RXTRIG = 4;
  localparam int CTL_TXTRIG = 16;
  localparam int TRIG_W = 7;

  typedef struct packed {
    logic [1:0] push;
    logic [1:0] pop;
    logic [1:0] flush;
  } fifoStrobe_t;
endpackage

// File: rtl/dfifo_datapath.sv
module dfifo_datapath
  import dfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVLW  = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  fifoStrobe_t     strobe,
  input  logic [7:0]      txIn,
  input  logic [7:0]      rxIn,
  output logic [LVLW-1:0] txLevel,
  output logic [LVLW-1:0] rxLevel,
  output logic [7:0]      txHead,
  output logic [7:0]      rxHead
);
  localparam int PTRW = $clog2(DEPTH);
  localparam logic [LVLW-1:0] FULLLVL = LVLW'(DEPTH);

  logic [7:0]      dinArr  [2];
  logic [LVLW-1:0] lvlArr  [2];
  logic [7:0]      headArr [2];

  assign dinArr[DIR_TX] = txIn;
  assign dinArr[DIR_RX] = rxIn;
  assign txLevel = lvlArr[DIR_TX];
  assign rxLevel = lvlArr[DIR_RX];
  assign txHead  = headArr[DIR_TX];
  assign rxHead  = headArr[DIR_RX];

  for (genvar d = 0; d < 2; d++) begin : g_ring
    logic [7:0]      mem [DEPTH];
    logic [PTRW-1:0] wrPtr, rdPtr;
    logic [LVLW-1:0] lvlR;
    logic            doPush, doPop;

    assign doPush = strobe.push[d] && !strobe.flush[d];
    assign doPop  = strobe.pop[d]  && !strobe.flush[d];

    always_ff @(posedge clk) begin
      if (doPush) mem[wrPtr] <= dinArr[d];
    end

    always_ff @(posedge clk) begin
      if (!rstN || strobe.flush[d]) begin
        wrPtr <= '0;
        rdPtr <= '0;
        lvlR  <= '0;
      end else begin
        if (doPush) wrPtr <= wrPtr + 1'b1;
        if (doPop)  rdPtr <= rdPtr + 1'b1;
        lvlR <= lvlR + LVLW'(doPush) - LVLW'(doPop);
      end
    end

    assign lvlArr[d]  = lvlR;
    assign headArr[d] = (lvlR == '0) ? 8'h00 : mem[rdPtr];

    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      lvlR <= FULLLVL);
    // R4
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.push[d] && lvlR == FULLLVL));
    // R5
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.pop[d] && lvlR == '0));
  end
endmodule

// File: rtl/dfifo_ctrl.sv
module dfifo_ctrl
  import dfifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LVLW   = 7,
  parameter int TRAILW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [31:0]       ctrlWdata,
  input  logic              trailWe,
  input  logic [TRAILW-1:0] trailWdata,
  input  logic              intEnWe,
  input  logic [INT_W-1:0]  intEnWdata,
  input  logic              intClrWe,
  input  logic [INT_W-1:0]  intClrWdata,
  input  logic              hostTxWe,
  input  logic              hostRxRe,
  input  logic              engTxRe,
  input  logic              engRxWe,
  input  logic [LVLW-1:0]   txLevel,
  input  logic [LVLW-1:0]   rxLevel,
  output fifoStrobe_t       strobe,
  output logic [31:0]       fifoStatus,
  output logic [INT_W-1:0]  intStatus,
  output logic [INT_W-1:0]  intEnable,
  output logic              irq
);
  localparam logic [LVLW-1:0]   FULLLVL   = LVLW'(DEPTH);
  localparam logic [TRAILW-1:0] TRAIL_RST = TRAILW'(15);

  logic              txEn, rxEn;
  logic [TRIG_W-1:0] txTrig, rxTrig;
  logic [TRAILW-1:0] trailLimit, trailCnt;
  logic              trailHit;
  logic [INT_W-1:0]  intSt, intEn, setVec, clrVec;

  logic txFull, txEmpty, rxFull, rxEmpty;
  logic txOver, txUnder, rxOver, rxUnder;
  logic txAlmostEmpty, rxAlmostFull, trailArmed, trailRestart, trailFire;
  logic [TRIG_W-1:0] txLvl7, rxLvl7;

  assign txLvl7  = TRIG_W'(txLevel);
  assign rxLvl7  = TRIG_W'(rxLevel);
  assign txFull  = (txLevel == FULLLVL);
  assign rxFull  = (rxLevel == FULLLVL);
  assign txEmpty = (txLevel == '0);
  assign rxEmpty = (rxLevel == '0);

  // request qualification and error detection
  always_comb begin
    strobe = '0;
    strobe.flush[DIR_TX] = !txEn;
    strobe.flush[DIR_RX] = !rxEn;
    strobe.push[DIR_TX]  = txEn && hostTxWe && !txFull;
    strobe.pop[DIR_TX]   = txEn && engTxRe  && !txEmpty;
    strobe.push[DIR_RX]  = rxEn && engRxWe  && !rxFull;
    strobe.pop[DIR_RX]   = rxEn && hostRxRe && !rxEmpty;
  end

  assign txOver  = txEn && hostTxWe && txFull;
  assign txUnder = txEn && engTxRe  && txEmpty;
  assign rxOver  = rxEn && engRxWe  && rxFull;
  assign rxUnder = rxEn && hostRxRe && rxEmpty;

  assign txAlmostEmpty = txEn && (txLvl7 <= txTrig);
  assign rxAlmostFull  = rxEn && (rxLvl7 >= rxTrig);

  // trailing idle timer
  assign trailArmed   = rxEn && !rxEmpty && (rxLvl7 < rxTrig);
  assign trailRestart = strobe.push[DIR_RX] || strobe.pop[DIR_RX] || !trailArmed;
  assign trailFire    = !trailRestart && (trailCnt == trailLimit) && !trailHit;

  always_ff @(posedge clk) begin
    if (!rstN || trailRestart) begin
      trailCnt <= '0;
      trailHit <= 1'b0;
    end else begin
      if (trailCnt != trailLimit) trailCnt <= trailCnt + 1'b1;
      if (trailFire) trailHit <= 1'b1;
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEn <= 1'b0;
      rxEn <= 1'b0;
      txTrig <= '0;
      rxTrig <= '0;
      trailLimit <= TRAIL_RST;
      intEn <= '0;
    end else begin
      if (ctrlWe) begin
        rxEn   <= ctrlWdata[CTL_RXEN];
        txEn   <= ctrlWdata[CTL_TXEN];
        rxTrig <= ctrlWdata[CTL_RXTRIG +: TRIG_W];
        txTrig <= ctrlWdata[CTL_TXTRIG +: TRIG_W];
      end
      if (trailWe) trailLimit <= trailWdata;
      if (intEnWe) intEn <= intEnWdata;
    end
  end

  // interrupt status: sources win over clears
  assign setVec = {trailFire, rxOver, rxUnder, txOver, txUnder, rxAlmostFull, txAlmostEmpty};
  assign clrVec = intClrWe ? intClrWdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) intSt <= '0;
    else       intSt <= (intSt & ~clrVec) | setVec;
  end

  assign intStatus  = intSt;
  assign intEnable  = intEn;
  assign irq        = |(intSt & intEn);
  assign fifoStatus = {7'b0, rxEmpty, rxFull, rxLvl7, 7'b0, txEmpty, txFull, txLvl7};

  // R4
  tx_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && hostTxWe && txLevel == FULLLVL) |=> intSt[3]);
  // R5
  rx_underrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxEn && hostRxRe && rxLevel == '0) |=> intSt[4]);
  // R11
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> (txLevel == '0));
  // R10
  trail_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intSt[6]) |-> ($past(rxLevel) != '0));
endmodule

// File: rtl/dual_fifo_irq.sv
module dual_fifo_irq
  import dfifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int TRAILW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [31:0]       ctrlWdata,
  input  logic              trailWe,
  input  logic [TRAILW-1:0] trailWdata,
  input  logic              intEnWe,
  input  logic [6:0]        intEnWdata,
  input  logic              intClrWe,
  input  logic [6:0]        intClrWdata,
  input  logic              hostTxWe,
  input  logic [7:0]        hostTxData,
  input  logic              hostRxRe,
  output logic [7:0]        hostRxData,
  input  logic              engTxRe,
  output logic [7:0]        engTxData,
  input  logic              engRxWe,
  input  logic [7:0]        engRxData,
  output logic [31:0]       fifoStatus,
  output logic [6:0]        intStatus,
  output logic [6:0]        intEnable,
  output logic              irq
);
  localparam int LVLW = $clog2(DEPTH) + 1;

  fifoStrobe_t     strobe;
  logic [LVLW-1:0] txLevel, rxLevel;

  dfifo_ctrl #(.DEPTH(DEPTH), .LVLW(LVLW), .TRAILW(TRAILW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .trailWe(trailWe), .trailWdata(trailWdata),
    .intEnWe(intEnWe), .intEnWdata(intEnWdata),
    .intClrWe(intClrWe), .intClrWdata(intClrWdata),
    .hostTxWe(hostTxWe), .hostRxRe(hostRxRe),
    .engTxRe(engTxRe), .engRxWe(engRxWe),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .strobe(strobe), .fifoStatus(fifoStatus),
    .intStatus(intStatus), .intEnable(intEnable), .irq(irq)
  );

  dfifo_datapath #(.DEPTH(DEPTH), .LVLW(LVLW)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txIn(hostTxData), .rxIn(engRxData),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txHead(engTxData), .rxHead(hostRxData)
  );
endmodule

// File: tb/dual_fifo_irq_test.sv
`timescale 1ns/1ps
module dual_fifo_irq_test;
  localparam int DEPTH  = 16;
  localparam int TRAILW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWe = 0, trailWe = 0, intEnWe = 0, intClrWe = 0;
  logic [31:0] ctrlWdata = 0;
  logic [TRAILW-1:0] trailWdata = 0;
  logic [6:0] intEnWdata = 0, intClrWdata = 0;
  logic hostTxWe = 0, hostRxRe = 0, engTxRe = 0, engRxWe = 0;
  logic [7:0] hostTxData = 0, engRxData = 0;
  logic [7:0] hostRxData, engTxData;
  logic [31:0] fifoStatus;
  logic [6:0] intStatus, intEnable;
  logic irq;

  always #2.5 clk = ~clk;

  dual_fifo_irq #(.DEPTH(DEPTH), .TRAILW(TRAILW)) uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit mTxEn, mRxEn;
  int mTxTrig, mRxTrig, mLim, mCnt;
  bit mHit;
  logic [6:0] mSt, mEn;
  logic [7:0] mTx[$], mRx[$];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatusWord();
    int tl = mTx.size(), rl = mRx.size();
    return {7'b0, rl == 0, rl == DEPTH, 7'(rl), 7'b0, tl == 0, tl == DEPTH, 7'(tl)};
  endfunction

  function automatic logic [31:0] ctlWord(bit rxE, bit txE, int rxT, int txT);
    return {9'b0, 7'(txT), 5'b0, 7'(rxT), 2'b0, txE, rxE};
  endfunction

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // one clock: inputs are already driven; apply model, compare after edge
  task automatic tick();
    int tl, rl;
    bit txPush, txPop, rxPush, rxPop, txO, txU, rxO, rxU, ae, af, armed, restart, fire;
    logic [6:0] nSt;
    #1;
    tl = mTx.size(); rl = mRx.size();
    if (hostRxRe) chk("R2", "rx read data", hostRxData, rl > 0 ? mRx[0] : 8'h00);
    if (engTxRe)  chk("R2", "tx pop data", engTxData, tl > 0 ? mTx[0] : 8'h00);
    txPush = mTxEn && hostTxWe && tl < DEPTH;  txO = mTxEn && hostTxWe && tl == DEPTH;
    txPop  = mTxEn && engTxRe && tl > 0;       txU = mTxEn && engTxRe && tl == 0;
    rxPush = mRxEn && engRxWe && rl < DEPTH;   rxO = mRxEn && engRxWe && rl == DEPTH;
    rxPop  = mRxEn && hostRxRe && rl > 0;      rxU = mRxEn && hostRxRe && rl == 0;
    ae = mTxEn && tl <= mTxTrig;
    af = mRxEn && rl >= mRxTrig;
    armed = mRxEn && rl > 0 && rl < mRxTrig;
    restart = rxPush || rxPop || !armed;
    fire = !restart && mCnt == mLim && !mHit;
    nSt = (mSt & ~(intClrWe ? intClrWdata : 7'h0)) | {fire, rxO, rxU, txO, txU, af, ae};
    if (restart) begin mCnt = 0; mHit = 0; end
    else begin if (mCnt != mLim) mCnt++; if (fire) mHit = 1; end
    if (!mTxEn) mTx.delete();
    else begin if (txPop) void'(mTx.pop_front()); if (txPush) mTx.push_back(hostTxData); end
    if (!mRxEn) mRx.delete();
    else begin if (rxPop) void'(mRx.pop_front()); if (rxPush) mRx.push_back(engRxData); end
    if (ctrlWe) begin
      mRxEn = ctrlWdata[0]; mTxEn = ctrlWdata[1];
      mRxTrig = int'(ctrlWdata[10:4]); mTxTrig = int'(ctrlWdata[22:16]);
    end
    if (trailWe) mLim = int'(trailWdata);
    if (intEnWe) mEn = intEnWdata;
    mSt = nSt;
    @(negedge clk);
    ctrlWe = 0; trailWe = 0; intEnWe = 0; intClrWe = 0;
    hostTxWe = 0; hostRxRe = 0; engTxRe = 0; engRxWe = 0;
    chk("R2", "status word", fifoStatus, expStatusWord());
    chk("R8", "int status", {25'b0, intStatus}, {25'b0, mSt});
    chk("R9", "irq", {31'b0, irq}, {31'b0, |(mSt & mEn)});
    chk("R9", "int enable", {25'b0, intEnable}, {25'b0, mEn});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask
  task automatic cfg(logic [31:0] w);
    ctrlWe = 1; ctrlWdata = w; tick();
  endtask
  task automatic clr(logic [6:0] m);
    intClrWe = 1; intClrWdata = m; tick();
  endtask
  task automatic hostWr(logic [7:0] b);
    hostTxWe = 1; hostTxData = b; tick();
  endtask
  task automatic engWr(logic [7:0] b);
    engRxWe = 1; engRxData = b; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    mTxEn = 0; mRxEn = 0; mTxTrig = 0; mRxTrig = 0; mLim = 15; mCnt = 0; mHit = 0;
    mSt = 0; mEn = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1", "reset status word", fifoStatus, 32'h0100_0100);
    chk("R1", "reset int status", {25'b0, intStatus}, 32'h0);
    chk("R1", "reset irq", {31'b0, irq}, 32'h0);
    chk("R1", "reset enable", {25'b0, intEnable}, 32'h0);
    chk("R1", "reset rx data", {24'b0, hostRxData}, 32'h0);

    // enable both, rx trigger 8, tx trigger 4, all interrupts unmasked
    cfg(ctlWord(1, 1, 8, 4));
    intEnWe = 1; intEnWdata = 7'h7F; tick();
    chk("R6", "tx almost-empty when empty", {31'b0, intStatus[0]}, 32'h1);

    // ordering through TX
    for (int i = 0; i < 6; i++) hostWr(8'h30 + 8'(i));
    clr(7'h7F);
    chk("R6", "almost-empty stays clear above trigger", {31'b0, intStatus[0]}, 32'h0);
    for (int i = 0; i < 6; i++) begin engTxRe = 1; tick(); end
    chk("R6", "almost-empty after drain", {31'b0, intStatus[0]}, 32'h1);

    // R5 tx underrun and rx underrun
    clr(7'h7F);
    engTxRe = 1; tick();
    chk("R5", "tx underrun bit", {31'b0, intStatus[2]}, 32'h1);
    hostRxRe = 1; tick();
    chk("R5", "rx underrun bit", {31'b0, intStatus[4]}, 32'h1);

    // R4 tx overrun: fill then one extra, extra byte never appears
    for (int i = 0; i < DEPTH; i++) hostWr(8'hA0 + 8'(i));
    chk("R3", "tx full flag", {31'b0, fifoStatus[7]}, 32'h1);
    hostWr(8'hEE);
    chk("R4", "tx overrun bit", {31'b0, intStatus[3]}, 32'h1);
    chk("R3", "tx level capped", {25'b0, fifoStatus[6:0]}, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin engTxRe = 1; tick(); end

    // R10 trailing with default limit 15
    clr(7'h7F);
    engWr(8'h11);
    idle(15);
    chk("R10", "no trailing before limit+1 edges", {31'b0, intStatus[6]}, 32'h0);
    idle(1);
    chk("R10", "trailing at limit+1 edges", {31'b0, intStatus[6]}, 32'h1);
    clr(7'h40);
    idle(20);
    chk("R10", "trailing fires once per idle span", {31'b0, intStatus[6]}, 32'h0);
    // restart by a second push
    hostRxRe = 1; tick();
    engWr(8'h22);
    idle(10);
    engWr(8'h23);
    idle(15);
    chk("R10", "push restarts idle count", {31'b0, intStatus[6]}, 32'h0);
    idle(1);
    chk("R10", "trailing after restart", {31'b0, intStatus[6]}, 32'h1);
    hostRxRe = 1; tick(); hostRxRe = 1; tick();

    // RX fill, overrun, almost-full, clear behaviour
    clr(7'h7F);
    for (int i = 0; i < DEPTH; i++) engWr(8'h50 + 8'(i));
    chk("R3", "rx full flag", {31'b0, fifoStatus[23]}, 32'h1);
    engWr(8'hFF);
    chk("R4", "rx overrun bit", {31'b0, intStatus[5]}, 32'h1);
    chk("R7", "rx almost-full", {31'b0, intStatus[1]}, 32'h1);
    clr(7'h22);
    chk("R8", "cleared overrun", {31'b0, intStatus[5]}, 32'h0);
    chk("R8", "active source wins over clear", {31'b0, intStatus[1]}, 32'h1);
    clr(7'h00);
    chk("R8", "zero clear keeps bits", {31'b0, intStatus[1]}, 32'h1);
    for (int i = 0; i < DEPTH; i++) begin hostRxRe = 1; tick(); end

    // R9 masking
    intEnWe = 1; intEnWdata = 7'h0; tick();
    chk("R9", "masked irq", {31'b0, irq}, 32'h0);
    intEnWe = 1; intEnWdata = 7'h7F; tick();

    // R11 disable TX with data
    hostWr(8'h01); hostWr(8'h02); hostWr(8'h03);
    cfg(ctlWord(1, 0, 8, 4));
    tick();
    chk("R11", "disabled tx flushed", {25'b0, fifoStatus[6:0]}, 32'h0);
    clr(7'h7F);
    hostWr(8'h99); engTxRe = 1; tick();
    chk("R11", "disabled tx ignores access", {25'b0, fifoStatus[6:0]}, 32'h0);
    chk("R11", "disabled tx sets no flag", {28'b0, intStatus[3:0]}, {28'b0, 3'b0, 1'b0});
    cfg(ctlWord(1, 1, 8, 4));

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      hostTxWe = ($urandom_range(0, 9) < 4); hostTxData = 8'($urandom);
      engTxRe  = ($urandom_range(0, 9) < 4);
      engRxWe  = ($urandom_range(0, 9) < 4); engRxData = 8'($urandom);
      hostRxRe = ($urandom_range(0, 9) < 4);
      if ($urandom_range(0, 19) == 0) begin intClrWe = 1; intClrWdata = 7'($urandom); end
      if ($urandom_range(0, 49) == 0) begin
        ctrlWe = 1;
        ctrlWdata = ctlWord($urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0,
                            $urandom_range(0, DEPTH), $urandom_range(0, DEPTH));
      end
      if ($urandom_range(0, 199) == 0) begin trailWe = 1; trailWdata = TRAILW'($urandom_range(0, 20)); end
      if ($urandom_range(0, 99) == 0) begin intEnWe = 1; intEnWdata = 7'($urandom); end
      tick();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule